// File: doc/BRIEF.md
# Coherent Sensor Result Register Bank

This block is a read-only register bank on a byte-wide host read port. It holds two 16-bit conversion results and a 16-bit integration timer value. A sampling front end loads the two results together with one strobe, and the timer value with a second strobe. The host reads one byte per access by address, or reads a whole 16-bit value in one word access.

A byte-wide host needs two accesses to collect a 16-bit value, and new results can arrive between them. To keep the two halves consistent, every source (each channel and the timer) has its own shadow byte. A read of a source's low byte copies that source's current upper byte into the shadow. A later high-byte read returns the shadow, not the live register. A constant identification byte sits beside the data.

Read data is registered. It appears on `rd_data` one cycle after the request, with `rd_vld` high in that cycle.

Top module: `snapreg_bank`

## Requirements
- R1: After synchronous reset, `rd_vld` is 0 and `rd_data` is 0000h. All live values and shadow bytes are 00h.
- R2: Byte reads use this map: channel 0 at 14h (low) and 15h (high), channel 1 at 16h and 17h, timer at 18h and 19h. The byte is returned in `rd_data[7:0]` with `rd_data[15:8]` = 00h, and it appears one cycle after `rd_en` with `rd_vld` = 1. `rd_vld` is 0 in the cycle after a cycle without `rd_en`.
- R3: `res_vld` loads `res_ch0` into channel 0 and `res_ch1` into channel 1. `tmr_vld` loads `tmr_val` into the timer.
- R4: A low-byte read copies that source's current upper byte into that source's shadow only. The other shadows keep their values.
- R5: A high-byte read returns the shadow byte. It matches the last low-byte read of that source even if new values were loaded in between.
- R6: A high-byte read with no earlier low-byte read of that source since reset returns 00h.
- R7: A word read (`rd_word` = 1) at a low-byte address returns the full 16-bit live value (low byte in [7:0], high byte in [15:8]). It also loads the shadow, as a low-byte read does.
- R8: When a load and a read of the same source fall in one cycle, the read returns the value held before the load, and any shadow capture takes that same older value. Later reads see the new value.
- R9: A byte read of 12h returns 00h in [15:8] and an identification byte in [7:0]. The upper nibble is 1001b and the lower nibble is the `REV_ID` parameter.
- R10: A byte read of an unmapped address returns 0000h and changes no shadow. A word read at any address other than 14h, 16h or 18h does the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_vld | input | 1 | Load strobe for both conversion results |
| res_ch0 | input | 16 | New channel 0 result |
| res_ch1 | input | 16 | New channel 1 result |
| tmr_vld | input | 1 | Load strobe for the timer value |
| tmr_val | input | 16 | New integration timer value |
| rd_en | input | 1 | Host read request |
| rd_addr | input | 8 | Host read address |
| rd_word | input | 1 | 1 = 16-bit word read, 0 = byte read |
| rd_vld | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | 16 | Read data |

## Verification
The bench first reads high bytes straight after reset, with no earlier low read, so it can tell a shadow read from a live read. It then splits low/high read pairs with fresh loads in between. This shows whether the shadow or the live byte is returned, and whether one source's capture leaks into another source's shadow. A load placed in the same cycle as a low read separates read-before-update from read-after-update. Word reads and unmapped or odd-address accesses, each followed by a high read, show that only the defined addresses touch the shadows.

// File: rtl/snapreg_pkg.sv
package snapreg_pkg;

    localparam int BYTE_W = 8;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 8;
    localparam int NSRC   = 3;
    localparam int SRC_W  = 2;

    localparam logic [ADDR_W-1:0] ID_ADDR  = 8'h12;
    localparam logic [ADDR_W-1:0] CH_BASE  = 8'h14;
    localparam logic [ADDR_W-1:0] TMR_BASE = 8'h18;
    localparam logic [3:0]        ID_PART  = 4'b1001;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_ID,
        SEL_LO,
        SEL_HI
    } sel_kind_e;

    typedef struct packed {
        sel_kind_e        kind;
        logic [SRC_W-1:0] src;
    } sel_t;

    function automatic logic [ADDR_W-1:0] lo_addr(input int idx);
        if (idx < NSRC - 1)
            return CH_BASE + ADDR_W'(2 * idx);
        return TMR_BASE;
    endfunction

    function automatic sel_t decode(input logic [ADDR_W-1:0] a, input logic word);
        sel_t s;
        s.kind = SEL_NONE;
        s.src  = '0;
        if (!word && a == ID_ADDR)
            s.kind = SEL_ID;
        for (int i = 0; i < NSRC; i++) begin
            if (a == lo_addr(i)) begin
                s.kind = SEL_LO;
                s.src  = SRC_W'(i);
            end else if (!word && a == lo_addr(i) + ADDR_W'(1)) begin
                s.kind = SEL_HI;
                s.src  = SRC_W'(i);
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/snap_source.sv
module snap_source #(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8,
    localparam int HI_W  = DATA_W - BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              snap,
    output logic [DATA_W-1:0] live_o,
    output logic [HI_W-1:0]   shad_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            live_o <= '0;
            shad_o <= '0;
        end else begin
            if (load)
                live_o <= load_val;
            if (snap)
                shad_o <= live_o[DATA_W-1:BYTE_W];
        end
    end

endmodule

// File: rtl/snap_rdmux.sv
module snap_rdmux
    import snapreg_pkg::*;
(
    input  sel_t                          sel,
    input  logic                          word,
    input  logic [3:0]                    rev,
    input  logic [NSRC-1:0][DATA_W-1:0]   live,
    input  logic [NSRC-1:0][BYTE_W-1:0]   shad,
    output logic [DATA_W-1:0]             data
);

    localparam int PAD_W = DATA_W - BYTE_W;

    always_comb begin
        data = '0;
        case (sel.kind)
            SEL_ID: data = {{PAD_W{1'b0}}, ID_PART, rev};
            SEL_LO: begin
                if (int'(sel.src) < NSRC)
                    data = word ? live[sel.src]
                                : {{PAD_W{1'b0}}, live[sel.src][BYTE_W-1:0]};
            end
            SEL_HI: begin
                if (int'(sel.src) < NSRC)
                    data = {{PAD_W{1'b0}}, shad[sel.src]};
            end
            default: data = '0;
        endcase
    end

endmodule

// File: rtl/snapreg_bank.sv
module snapreg_bank
    import snapreg_pkg::*;
#(
    parameter logic [3:0] REV_ID = 4'h6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              res_vld,
    input  logic [DATA_W-1:0] res_ch0,
    input  logic [DATA_W-1:0] res_ch1,
    input  logic              tmr_vld,
    input  logic [DATA_W-1:0] tmr_val,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_word,
    output logic              rd_vld,
    output logic [DATA_W-1:0] rd_data
);

    sel_t                         sel;
    logic [NSRC-1:0]              ld;
    logic [NSRC-1:0]              snap;
    logic [NSRC-1:0][DATA_W-1:0]  ld_val;
    logic [NSRC-1:0][DATA_W-1:0]  live_q;
    logic [NSRC-1:0][BYTE_W-1:0]  shad_q;
    logic [DATA_W-1:0]            mux_data;

    assign sel = decode(rd_addr, rd_word);

    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_src
            if (g == NSRC - 1) begin : g_tmr
                assign ld[g]     = tmr_vld;
                assign ld_val[g] = tmr_val;
            end else if (g == 0) begin : g_ch0
                assign ld[g]     = res_vld;
                assign ld_val[g] = res_ch0;
            end else begin : g_ch1
                assign ld[g]     = res_vld;
                assign ld_val[g] = res_ch1;
            end

            assign snap[g] = rd_en && (sel.kind == SEL_LO) && (int'(sel.src) == g);

            snap_source #(
                .DATA_W (DATA_W),
                .BYTE_W (BYTE_W)
            ) u_src (
                .clk      (clk),
                .rst      (rst),
                .load     (ld[g]),
                .load_val (ld_val[g]),
                .snap     (snap[g]),
                .live_o   (live_q[g]),
                .shad_o   (shad_q[g])
            );
        end
    endgenerate

    snap_rdmux u_mux (
        .sel  (sel),
        .word (rd_word),
        .rev  (REV_ID),
        .live (live_q),
        .shad (shad_q),
        .data (mux_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_vld  <= 1'b0;
            rd_data <= '0;
        end else begin
            rd_vld  <= rd_en;
            rd_data <= rd_en ? mux_data : '0;
        end
    end

endmodule

// File: rtl/snapreg_bank_chk.sv
module snapreg_bank_chk
    import snapreg_pkg::*;
#(
    parameter logic [3:0] REV_ID = 4'h6
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         res_vld,
    input logic [DATA_W-1:0]            res_ch0,
    input logic                         rd_en,
    input logic [ADDR_W-1:0]            rd_addr,
    input logic                         rd_word,
    input logic                         rd_vld,
    input logic [DATA_W-1:0]            rd_data,
    input logic [NSRC-1:0][DATA_W-1:0]  live,
    input logic [NSRC-1:0][BYTE_W-1:0]  shad
);

    logic rd_ch0_lo;
    logic rd_id;
    logic rd_unmapped;

    assign rd_ch0_lo   = rd_en && rd_addr == CH_BASE;
    assign rd_id       = rd_en && !rd_word && rd_addr == ID_ADDR;
    assign rd_unmapped = rd_en && decode(rd_addr, rd_word).kind == SEL_NONE;

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!rd_vld && rd_data == '0));

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_vld);

    a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_vld);

    a_r3_ch0_load: assert property (@(posedge clk) disable iff (rst)
        res_vld |=> live[0] == $past(res_ch0));

    a_r4_snap_ch0: assert property (@(posedge clk) disable iff (rst)
        rd_ch0_lo |=> shad[0] == $past(live[0][DATA_W-1:BYTE_W]));

    a_r4_other_shadow_kept: assert property (@(posedge clk) disable iff (rst)
        rd_ch0_lo |=> ($stable(shad[1]) && $stable(shad[2])));

    a_r9_id_byte: assert property (@(posedge clk) disable iff (rst)
        rd_id |=> rd_data == {8'h00, 4'b1001, REV_ID});

    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        rd_unmapped |=> rd_data == '0);

    a_r10_unmapped_no_snap: assert property (@(posedge clk) disable iff (rst)
        rd_unmapped |=> $stable(shad));

endmodule

bind snapreg_bank snapreg_bank_chk #(.REV_ID(REV_ID)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .res_vld (res_vld),
    .res_ch0 (res_ch0),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_word (rd_word),
    .rd_vld  (rd_vld),
    .rd_data (rd_data),
    .live    (live_q),
    .shad    (shad_q)
);

// File: tb/test_snapreg_bank.sv
`timescale 1ns/1ps
module test_snapreg_bank;

    localparam logic [3:0] REV = 4'h6;

    logic        clk = 1'b0;
    logic        rst;
    logic        res_vld;
    logic [15:0] res_ch0;
    logic [15:0] res_ch1;
    logic        tmr_vld;
    logic [15:0] tmr_val;
    logic        rd_en;
    logic [7:0]  rd_addr;
    logic        rd_word;
    logic        rd_vld;
    logic [15:0] rd_data;

    int n_cmp = 0;
    int n_bad = 0;

    logic [15:0] m_live [3];
    logic [7:0]  m_shad [3];
    logic [15:0] exp_q [$];
    string       req_q [$];

    always #5 clk = ~clk;

    snapreg_bank #(.REV_ID(REV)) i_snapreg_bank (
        .clk     (clk),
        .rst     (rst),
        .res_vld (res_vld),
        .res_ch0 (res_ch0),
        .res_ch1 (res_ch1),
        .tmr_vld (tmr_vld),
        .tmr_val (tmr_val),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_word (rd_word),
        .rd_vld  (rd_vld),
        .rd_data (rd_data)
    );

    function automatic int lo_of(input logic [7:0] a);
        case (a)
            8'h14: return 0;
            8'h16: return 1;
            8'h18: return 2;
            default: return -1;
        endcase
    endfunction

    function automatic int hi_of(input logic [7:0] a);
        case (a)
            8'h15: return 0;
            8'h17: return 1;
            8'h19: return 2;
            default: return -1;
        endcase
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One cycle of stimulus: optional read, optional loads. Expected read data
    // comes from the pre-load model state.
    task automatic cyc(input logic rd, input logic [7:0] a, input logic w,
                       input logic rv, input logic [15:0] c0, input logic [15:0] c1,
                       input logic tv, input logic [15:0] t, input string req);
        logic [15:0] e;
        int lo;
        int hi;
        @(negedge clk);
        rd_en = rd; rd_addr = a; rd_word = w;
        res_vld = rv; res_ch0 = c0; res_ch1 = c1;
        tmr_vld = tv; tmr_val = t;
        if (rd) begin
            lo = lo_of(a);
            hi = hi_of(a);
            e = 16'h0000;
            if (lo >= 0) begin
                e = w ? m_live[lo] : {8'h00, m_live[lo][7:0]};
                m_shad[lo] = m_live[lo][15:8];
            end else if (!w && hi >= 0) begin
                e = {8'h00, m_shad[hi]};
            end else if (!w && a == 8'h12) begin
                e = {8'h00, 4'b1001, REV};
            end
            exp_q.push_back(e);
            req_q.push_back(req);
        end
        if (rv) begin
            m_live[0] = c0;
            m_live[1] = c1;
        end
        if (tv) m_live[2] = t;
    endtask

    task automatic rdb(input logic [7:0] a, input string req);
        cyc(1'b1, a, 1'b0, 1'b0, 16'h0, 16'h0, 1'b0, 16'h0, req);
    endtask

    task automatic rdw(input logic [7:0] a, input string req);
        cyc(1'b1, a, 1'b1, 1'b0, 16'h0, 16'h0, 1'b0, 16'h0, req);
    endtask

    task automatic load(input logic [15:0] c0, input logic [15:0] c1);
        cyc(1'b0, 8'h00, 1'b0, 1'b1, c0, c1, 1'b0, 16'h0, "R3");
    endtask

    task automatic idle();
        cyc(1'b0, 8'h00, 1'b0, 1'b0, 16'h0, 16'h0, 1'b0, 16'h0, "idle");
    endtask

    // Monitor: pops and compares each result as the design produces it.
    always @(negedge clk) begin
        if (!rst) begin
            if (rd_vld) begin
                if (exp_q.size() == 0) begin
                    check("R2 unexpected rd_vld", 16'h0001, 16'h0000);
                end else begin
                    check(req_q.pop_front(), rd_data, exp_q.pop_front());
                end
            end else if (exp_q.size() > 0 && !rd_en) begin
                check("R2 missing rd_vld", 16'h0000, 16'h0001);
                void'(exp_q.pop_front());
                void'(req_q.pop_front());
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        check("watchdog expired", 16'h0000, 16'h0001);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 3; i++) begin
            m_live[i] = 16'h0;
            m_shad[i] = 8'h0;
        end
        rst = 1'b1;
        rd_en = 0; rd_addr = 0; rd_word = 0;
        res_vld = 0; res_ch0 = 0; res_ch1 = 0; tmr_vld = 0; tmr_val = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 rd_vld after reset", {15'h0, rd_vld}, 16'h0000);
        check("R1 rd_data after reset", rd_data, 16'h0000);
        rst = 1'b0;

        // R6 / R1: high reads with no prior low read return 00h
        rdb(8'h15, "R6 ch0 hi no low");
        rdb(8'h17, "R6 ch1 hi no low");
        rdb(8'h19, "R6 tmr hi no low");
        rdb(8'h14, "R1 ch0 lo reset value");

        // R9 identification byte
        rdb(8'h12, "R9 id byte");

        // R3 loads, R2 byte map, R4/R5 pairs
        load(16'hA1B2, 16'hC3D4);
        cyc(1'b0, 8'h00, 1'b0, 1'b0, 16'h0, 16'h0, 1'b1, 16'h5E6F, "R3 timer");
        rdb(8'h14, "R2 R3 ch0 lo");
        rdb(8'h15, "R2 R5 ch0 hi");
        rdb(8'h16, "R2 R3 ch1 lo");
        rdb(8'h17, "R2 R5 ch1 hi");
        rdb(8'h18, "R2 R3 tmr lo");
        rdb(8'h19, "R2 R5 tmr hi");

        // R5 coherence across an update
        rdb(8'h14, "R5 ch0 lo before update");
        load(16'h1122, 16'h3344);
        idle();
        rdb(8'h15, "R5 ch0 hi keeps old shadow");
        rdb(8'h14, "R5 ch0 lo new value");

        // R4 isolation between sources
        rdb(8'h16, "R4 ch1 lo capture");
        load(16'h5566, 16'h7788);
        rdb(8'h14, "R4 ch0 lo capture");
        rdb(8'h18, "R4 tmr lo capture");
        rdb(8'h17, "R4 ch1 shadow untouched");
        rdb(8'h15, "R4 ch0 shadow own value");

        // R7 word reads
        rdw(8'h14, "R7 ch0 word");
        rdw(8'h16, "R7 ch1 word");
        rdw(8'h18, "R7 tmr word");
        load(16'h9900, 16'h0099);
        rdb(8'h17, "R7 word read loaded shadow");

        // R10 word reads at other addresses
        rdw(8'h15, "R10 word at hi addr");
        rdw(8'h12, "R10 word at id addr");
        rdb(8'h15, "R10 shadow kept after odd word");

        // R8 same-cycle load and low read
        cyc(1'b1, 8'h14, 1'b0, 1'b1, 16'hABCD, 16'hEF01, 1'b0, 16'h0, "R8 lo read sees old");
        rdb(8'h15, "R8 shadow took old upper");
        rdb(8'h14, "R8 lo read sees new");
        cyc(1'b1, 8'h18, 1'b1, 1'b0, 16'h0, 16'h0, 1'b1, 16'h2468, "R8 word read sees old timer");
        rdw(8'h18, "R8 word read sees new timer");

        // R10 unmapped
        rdb(8'h00, "R10 unmapped 00");
        rdb(8'h13, "R10 unmapped 13");
        rdb(8'h1A, "R10 unmapped 1A");
        rdb(8'hFF, "R10 unmapped FF");
        load(16'h0F0F, 16'hF0F0);
        rdb(8'h15, "R10 ch0 shadow unchanged");
        rdb(8'h19, "R10 tmr shadow unchanged");

        idle();
        idle();
        idle();
        check("R2 all reads answered", 16'(exp_q.size()), 16'h0000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule